// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block sits at the head of an Ethernet receive path and decides, from the 48-bit destination address alone, whether the frame is kept. The address arrives one byte per accepted cycle, first byte first, with a marker on the first byte. While the bytes stream in, the block compares them against a programmable station address and checks for the all-ones broadcast address. It also runs a bit-serial CRC-32 over them, and the CRC selects one bit of a 64-bit multicast hash table.

One cycle after the sixth byte, the block pulses a decision strobe. With the strobe it presents an accept bit and three class flags (broadcast, own-address match, hashed multicast). The same flags also appear at fixed positions of a 16-bit status word for the receive descriptor. The station address, hash table and accept enables are loaded through a plain select/data write port. Frame checksum checking, error screening and DMA belong to other blocks.

Top module: `rxaddr_filter`

## Requirements
- R1: Synchronous active-high reset clears the decision strobe, the accept bit, the class flags and the status word. It also sets the station address, the hash table and all accept enables to zero.
- R2: `byte_first` with `byte_valid` starts an address as byte 0. Later bytes count only when `byte_valid` is high, so idle cycles may sit between bytes. `dec_valid` is high for exactly the one cycle after the clock edge that takes byte 5. Valid bytes that arrive with no address started are ignored.
- R3: An all-ones destination sets the broadcast flag only, with the own-address and multicast flags low. The broadcast flag is status bit 13.
- R4: When all six bytes equal the station address, the own-address flag is set. The station address is loaded as follows: select 0 carries bytes 3..0 with byte 0 in bits 7:0, and select 1 carries bytes 5..4 in bits 15:0. The own-address flag is status bit 14.
- R5: The multicast flag is set when bit 0 of byte 0 is 1, the address is not broadcast, and the selected hash table bit is 1. The multicast flag is status bit 15. Status bits 12:0 are zero.
- R6: The hash CRC starts at all ones for every address and takes each byte least significant bit first. On each bit, the feedback is CRC bit 31 XOR the data bit. The CRC then shifts left one place and, when the feedback is 1, is XORed with 0x04C11DB7. The table index is CRC bits 31:26 after the last byte.
- R7: Select 2 writes hash table bits 31:0 and select 3 writes bits 63:32. Writes with selects 5 to 7 change nothing.
- R8: Select 4 bits 3:0 are the accept enables: bit 0 accept everything, bit 1 own address, bit 2 multicast, bit 3 broadcast. The accept bit is high when accept-everything is set, or when a raised class flag has its enable set.
- R9: With accept-everything set, an address that raises no class flag is still accepted, and its flags stay low.
- R10: A `byte_first` in the middle of an address discards the partial address and starts again at byte 0.
- R11: The accept bit, the flags and the status word keep their values between decision strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration target select (0..4 used) |
| cfg_wdata | input | 32 | Configuration write data |
| byte_valid | input | 1 | Address byte present this cycle |
| byte_first | input | 1 | This byte is byte 0 of a new address |
| byte_data | input | 8 | Address byte |
| dec_valid | output | 1 | One-cycle decision strobe |
| rx_accept | output | 1 | Frame accepted |
| rx_bcast | output | 1 | Broadcast address seen |
| rx_phys | output | 1 | Station address matched |
| rx_mcast | output | 1 | Hashed multicast matched |
| rx_status | output | 16 | Status word with class flags in bits 15:13 |

## Verification
The hash is checked by programming only the bit the bench's own CRC model picks for a group address, and then only its neighbour. A design that reversed the bit order within a byte, used the wrong end of the CRC or swapped the table words would accept in the wrong one of the two runs. The bench sends a broadcast frame with the multicast and own-address enables set; a design that let broadcast also raise the multicast flag would accept it wrongly. Addresses that differ only in the last byte, addresses restarted mid-way, addresses with idle gaps and stray bytes with no start marker are all sent. These catch designs that decide early, count gap cycles or keep stale compare state. After each decision the outputs are sampled again, so a design that clears its flags after the strobe is caught.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int          ADDR_BYTES  = 6;
    localparam int          HASH_BITS   = 64;
    localparam int          CFG_W       = 32;
    localparam int          STATUS_W    = 16;
    localparam int          CRC_W       = 32;
    localparam logic [31:0] CRC_POLY    = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED    = 32'hFFFF_FFFF;
    localparam int          STAT_BC_BIT = 13;
    localparam int          STAT_PH_BIT = 14;
    localparam int          STAT_MC_BIT = 15;

    typedef enum logic [2:0] {
        SEL_STA_LO  = 3'd0,
        SEL_STA_HI  = 3'd1,
        SEL_HASH_LO = 3'd2,
        SEL_HASH_HI = 3'd3,
        SEL_MODE    = 3'd4
    } cfg_sel_e;

    // bit order equals write-data bits 3:0
    typedef struct packed {
        logic bcast_en;
        logic mcast_en;
        logic phys_en;
        logic all_en;
    } accept_mode_t;

    typedef struct packed {
        logic mcast;
        logic phys;
        logic bcast;
    } addr_class_t;

    // one address byte into the hash CRC, low bit first
    function automatic logic [CRC_W-1:0] crc_feed_byte(input logic [CRC_W-1:0] c_in,
                                                       input logic [7:0]       d);
        logic [CRC_W-1:0] c;
        logic             fb;
        c = c_in;
        for (int i = 0; i < 8; i++) begin
            fb = c[CRC_W-1] ^ d[i];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
    import rxf_pkg::*;
#(
    parameter int HASH_W = HASH_BITS
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [2:0]                sel,
    input  logic [CFG_W-1:0]          wdata,
    output logic [ADDR_BYTES*8-1:0]   station,
    output logic [HASH_W-1:0]         hash_tbl,
    output accept_mode_t              mode
);
    localparam int HASH_WORDS = HASH_W / CFG_W;
    localparam int STA_HI_W   = ADDR_BYTES*8 - CFG_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            station <= '0;
            mode    <= '0;
        end else if (we) begin
            case (sel)
                SEL_STA_LO: station[CFG_W-1:0]            <= wdata;
                SEL_STA_HI: station[ADDR_BYTES*8-1:CFG_W] <= wdata[STA_HI_W-1:0];
                SEL_MODE:   mode                          <= accept_mode_t'(wdata[3:0]);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hash_tbl <= '0;
        end else if (we) begin
            for (int w = 0; w < HASH_WORDS; w++) begin
                if (sel == 3'(int'(SEL_HASH_LO) + w))
                    hash_tbl[w*CFG_W +: CFG_W] <= wdata;
            end
        end
    end

endmodule

// File: rtl/rxf_addr_track.sv
module rxf_addr_track
    import rxf_pkg::*;
#(
    parameter int NBYTES = ADDR_BYTES,
    parameter int HASH_W = HASH_BITS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  byte_valid,
    input  logic                  byte_first,
    input  logic [7:0]            byte_data,
    input  logic [NBYTES*8-1:0]   station,
    input  logic [HASH_W-1:0]     hash_tbl,
    output logic                  last_fire,
    output addr_class_t           cls_now
);
    localparam int CNT_W = $clog2(NBYTES);
    localparam int IDX_W = $clog2(HASH_W);

    logic [7:0] sta_b [NBYTES];

    for (genvar g = 0; g < NBYTES; g++) begin : g_sta_bytes
        assign sta_b[g] = station[g*8 +: 8];
    end

    logic             busy_q, eq_q, ones_q, grp_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CRC_W-1:0] crc_q;

    logic             take, eq_nxt, ones_nxt, grp_nxt;
    logic [CNT_W-1:0] pos;
    logic [CRC_W-1:0] crc_nxt;
    logic [IDX_W-1:0] hidx;

    always_comb begin
        take      = byte_valid && (byte_first || busy_q);
        pos       = byte_first ? '0 : cnt_q;
        crc_nxt   = crc_feed_byte(byte_first ? CRC_SEED : crc_q, byte_data);
        eq_nxt    = (byte_first || eq_q)   && (byte_data == sta_b[pos]);
        ones_nxt  = (byte_first || ones_q) && (byte_data == 8'hFF);
        grp_nxt   = byte_first ? byte_data[0] : grp_q;
        hidx      = crc_nxt[CRC_W-1 -: IDX_W];
        last_fire = take && (pos == CNT_W'(NBYTES-1));
        cls_now.bcast = ones_nxt;
        cls_now.phys  = eq_nxt && !ones_nxt;
        cls_now.mcast = grp_nxt && !ones_nxt && hash_tbl[hidx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            crc_q  <= CRC_SEED;
            eq_q   <= 1'b0;
            ones_q <= 1'b0;
            grp_q  <= 1'b0;
        end else if (take) begin
            crc_q  <= crc_nxt;
            eq_q   <= eq_nxt;
            ones_q <= ones_nxt;
            grp_q  <= grp_nxt;
            if (last_fire) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                busy_q <= 1'b1;
                cnt_q  <= pos + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
    import rxf_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         fire,
    input  addr_class_t  cls,
    input  accept_mode_t mode,
    output logic         dec_valid,
    output logic         accept,
    output addr_class_t  cls_q
);
    logic accept_nxt;

    always_comb begin
        accept_nxt = mode.all_en
                   | (cls.bcast & mode.bcast_en)
                   | (cls.phys  & mode.phys_en)
                   | (cls.mcast & mode.mcast_en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid <= 1'b0;
            accept    <= 1'b0;
            cls_q     <= '0;
        end else begin
            dec_valid <= fire;
            if (fire) begin
                accept <= accept_nxt;
                cls_q  <= cls;
            end
        end
    end

endmodule

// File: rtl/rxaddr_filter.sv
module rxaddr_filter
    import rxf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [2:0]          cfg_sel,
    input  logic [CFG_W-1:0]    cfg_wdata,
    input  logic                byte_valid,
    input  logic                byte_first,
    input  logic [7:0]          byte_data,
    output logic                dec_valid,
    output logic                rx_accept,
    output logic                rx_bcast,
    output logic                rx_phys,
    output logic                rx_mcast,
    output logic [STATUS_W-1:0] rx_status
);
    logic [ADDR_BYTES*8-1:0] station;
    logic [HASH_BITS-1:0]    hash_tbl;
    accept_mode_t            mode_q;
    addr_class_t             cls_now, cls_q;
    logic                    last_fire;

    rxf_cfg_regs #(.HASH_W(HASH_BITS)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .sel      (cfg_sel),
        .wdata    (cfg_wdata),
        .station  (station),
        .hash_tbl (hash_tbl),
        .mode     (mode_q)
    );

    rxf_addr_track #(.NBYTES(ADDR_BYTES), .HASH_W(HASH_BITS)) u_track (
        .clk        (clk),
        .rst        (rst),
        .byte_valid (byte_valid),
        .byte_first (byte_first),
        .byte_data  (byte_data),
        .station    (station),
        .hash_tbl   (hash_tbl),
        .last_fire  (last_fire),
        .cls_now    (cls_now)
    );

    rxf_decide u_dec (
        .clk       (clk),
        .rst       (rst),
        .fire      (last_fire),
        .cls       (cls_now),
        .mode      (mode_q),
        .dec_valid (dec_valid),
        .accept    (rx_accept),
        .cls_q     (cls_q)
    );

    always_comb begin
        rx_bcast  = cls_q.bcast;
        rx_phys   = cls_q.phys;
        rx_mcast  = cls_q.mcast;
        rx_status = '0;
        rx_status[STAT_BC_BIT] = cls_q.bcast;
        rx_status[STAT_PH_BIT] = cls_q.phys;
        rx_status[STAT_MC_BIT] = cls_q.mcast;
    end

endmodule

// File: rtl/rxaddr_filter_chk.sv
module rxaddr_filter_chk (
    input logic        clk,
    input logic        rst,
    input logic        dec_valid,
    input logic        rx_accept,
    input logic        rx_bcast,
    input logic        rx_phys,
    input logic        rx_mcast,
    input logic [15:0] rx_status,
    input logic        mode_all
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !dec_valid && !rx_accept && rx_status == 16'h0); // R1

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
        dec_valid |=> !dec_valid); // R2

    AST_BCAST_ALONE: assert property (@(posedge clk) disable iff (rst)
        dec_valid && rx_bcast |-> !rx_phys && !rx_mcast); // R3

    AST_ALL_ACCEPTS: assert property (@(posedge clk) disable iff (rst)
        dec_valid && $past(mode_all) |-> rx_accept); // R9

    AST_NO_CLASS_REJECT: assert property (@(posedge clk) disable iff (rst)
        dec_valid && !$past(mode_all) && !rx_bcast && !rx_phys && !rx_mcast |-> !rx_accept); // R8

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |-> $stable(rx_accept) && $stable(rx_status)); // R11

endmodule

bind rxaddr_filter rxaddr_filter_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .dec_valid (dec_valid),
    .rx_accept (rx_accept),
    .rx_bcast  (rx_bcast),
    .rx_phys   (rx_phys),
    .rx_mcast  (rx_mcast),
    .rx_status (rx_status),
    .mode_all  (mode_q.all_en)
);

// File: tb/rxaddr_filter_tb_top.sv
module rxaddr_filter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    localparam logic [47:0] STA = 48'h5544_3322_1100;
    localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] MC1 = 48'h0100_005E_0001;
    localparam logic [47:0] MC2 = 48'h0100_0000_3333;

    typedef struct packed {
        logic [47:0] addr;
        logic [3:0]  mode;
        logic        fill;
        logic [2:0]  cls;   // {bcast, phys, mcast}
        logic        acc;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{BC,              4'b1000, 1'b1, 3'b100, 1'b1},
        '{BC,              4'b0110, 1'b1, 3'b100, 1'b0},
        '{STA,             4'b0010, 1'b1, 3'b010, 1'b1},
        '{STA,             4'b1100, 1'b1, 3'b010, 1'b0},
        '{48'h554433221102, 4'b0010, 1'b1, 3'b000, 1'b0},
        '{48'h554433221102, 4'b0001, 1'b0, 3'b000, 1'b1},
        '{MC1,             4'b0100, 1'b1, 3'b001, 1'b1},
        '{MC1,             4'b0100, 1'b0, 3'b000, 1'b0},
        '{MC1,             4'b1010, 1'b1, 3'b001, 1'b0},
        '{48'h564433221100, 4'b0010, 1'b1, 3'b000, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        byte_valid = 1'b0;
    logic        byte_first = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        dec_valid, rx_accept, rx_bcast, rx_phys, rx_mcast;
    logic [15:0] rx_status;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    rxaddr_filter dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .byte_valid(byte_valid), .byte_first(byte_first), .byte_data(byte_data),
        .dec_valid(dec_valid), .rx_accept(rx_accept), .rx_bcast(rx_bcast),
        .rx_phys(rx_phys), .rx_mcast(rx_mcast), .rx_status(rx_status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc == WATCHDOG) begin
            bad++;
            total++;
            $display("FAIL R2 watchdog act=%0d exp<%0d", cyc, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // independent model of the hash CRC (shift, xor 0x04C11DB6, or in carry)
    function automatic logic [5:0] ref_index(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        logic        carry;
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 8; j++) begin
                carry = c[31] ^ a[i*8+j];
                c = c << 1;
                if (carry) c = (c ^ 32'h04C1_1DB6) | 32'h1;
            end
        end
        return c[31:26];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // ends on the negedge after the edge that takes byte 5
    task automatic send_addr(input logic [47:0] a, input int gap);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            byte_valid = 1'b1; byte_first = (i == 0); byte_data = a[i*8 +: 8];
            if (i < 5) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    byte_valid = 1'b0; byte_first = 1'b0; byte_data = 8'hA5;
                end
            end
        end
        @(negedge clk);
        byte_valid = 1'b0; byte_first = 1'b0;
    endtask

    task automatic chk_dec(input string req, input logic [2:0] cls, input logic acc);
        chk({req, " strobe"}, 32'(dec_valid), 32'd1);
        chk({req, " class"},  32'({rx_bcast, rx_phys, rx_mcast}), 32'(cls));
        chk({req, " status"}, 32'(rx_status), 32'({cls[0], cls[1], cls[2], 13'd0}));
        chk({req, " accept"}, 32'(rx_accept), 32'(acc));
    endtask

    task automatic set_hash(input logic [63:0] h);
        cfg_write(3'd2, h[31:0]);
        cfg_write(3'd3, h[63:32]);
    endtask

    initial begin
        logic [5:0]  idx;
        logic [63:0] h;
        logic [2:0]  held_cls;
        logic        held_acc;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        chk("R1 strobe", 32'(dec_valid), 32'd0);
        chk("R1 accept", 32'(rx_accept), 32'd0);
        chk("R1 status", 32'(rx_status), 32'd0);
        // R1: station cleared to zero, phys enable only
        cfg_write(3'd4, 32'h2);
        send_addr(48'h0, 0);
        chk_dec("R1 zero station", 3'b010, 1'b1);
        // R1: hash table cleared
        cfg_write(3'd4, 32'h4);
        send_addr(MC1, 0);
        chk_dec("R1 empty hash", 3'b000, 1'b0);

        cfg_write(3'd0, STA[31:0]);
        cfg_write(3'd1, {16'h0, STA[47:32]});

        // table walk: R3 R4 R5 R8 R9
        for (int k = 0; k < NV; k++) begin
            vec_t v;
            v = VECS[k];
            set_hash(v.fill ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0);
            cfg_write(3'd4, {28'h0, v.mode});
            send_addr(v.addr, 0);
            chk_dec($sformatf("R3/R4/R5/R8/R9 vec%0d", k), v.cls, v.acc);
        end

        // R6 R7: only the computed hash bit set, then only its neighbour
        cfg_write(3'd4, 32'h4);
        for (int m = 0; m < 2; m++) begin
            logic [47:0] a;
            a = (m == 0) ? MC1 : MC2;
            idx = ref_index(a);
            h = 64'd1 << idx;
            set_hash(h);
            send_addr(a, 0);
            chk_dec($sformatf("R6 R7 hash idx %0d hit", idx), 3'b001, 1'b1);
            h = 64'd1 << (idx ^ 6'd1);
            set_hash(h);
            send_addr(a, 0);
            chk_dec($sformatf("R6 R7 hash idx %0d neighbour", idx), 3'b000, 1'b0);
        end

        // R7: unused selects change nothing
        cfg_write(3'd4, 32'h2);
        cfg_write(3'd5, 32'hDEAD_BEEF);
        cfg_write(3'd6, 32'hDEAD_BEEF);
        cfg_write(3'd7, 32'hDEAD_BEEF);
        send_addr(STA, 0);
        chk_dec("R7 unused select", 3'b010, 1'b1);

        // R2: idle gaps between bytes
        send_addr(STA, 2);
        chk_dec("R2 gapped bytes", 3'b010, 1'b1);
        // R11: outputs hold after strobe
        held_cls = {rx_bcast, rx_phys, rx_mcast};
        held_acc = rx_accept;
        @(negedge clk);
        chk("R2 strobe one cycle", 32'(dec_valid), 32'd0);
        chk("R11 hold class", 32'({rx_bcast, rx_phys, rx_mcast}), 32'(held_cls));
        chk("R11 hold accept", 32'(rx_accept), 32'(held_acc));

        // R2: valid bytes without a start are ignored
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            byte_valid = 1'b1; byte_first = 1'b0; byte_data = 8'hFF;
            if (i > 0) chk("R2 stray bytes", 32'(dec_valid), 32'd0);
        end
        @(negedge clk);
        byte_valid = 1'b0;
        chk("R2 stray bytes end", 32'(dec_valid), 32'd0);

        // R10: restart mid-address
        cfg_write(3'd4, 32'hA);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            byte_valid = 1'b1; byte_first = (i == 0); byte_data = 8'hFF;
        end
        send_addr(STA, 0);
        chk_dec("R10 restart", 3'b010, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule